// File: doc/BRIEF.md
# PWM Counter Event Interrupt and Trigger Unit

This unit sits beside the up/down counter of a PWM generator. It compares the counter against the period (load) value, zero and two compare thresholds, A and B. The two compare matches are split by counting direction, so there are six event sources. Events are sampled only in a cycle where the counter's advance strobe is high. A counter that holds its value therefore raises nothing new.

Each event sets its own bit in a sticky raw-status register, whether or not the event is enabled. Software clears a bit by writing a one to it. A 32-bit enable register holds two independent 6-bit masks: one selects which status bits drive the interrupt level, and the other selects which events fire the ADC trigger. The trigger is a single-cycle pulse. It carries no record of its cause, and several enabled events in one sample give a single pulse.

Top module: `pwm_event_gen`

## Requirements
- R1: After reset the enable register reads 0, the raw status is 0, and the interrupt and trigger outputs are low.
- R2: A write with `regSel`=0 loads the enable register. Bits 5:0 are the interrupt enables and bits 13:8 are the trigger enables. Bits 31:14 and 7:6 always read 0, whatever was written to them.
- R3: Event bit positions are: 0 counter equals zero, 1 counter equals load, 2 compare A while counting up, 3 compare A while counting down, 4 compare B while counting up, 5 compare B while counting down. The same order holds in the status register and in both enable masks. `cntDown`=1 means counting down.
- R4: With `cntAdv` low, no status bit sets and no trigger fires, whatever the counter inputs are.
- R5: A status bit sets on the clock edge that samples its event, even when that event is disabled in both masks.
- R6: A write with `regSel`=1 clears every status bit whose data bit is 1 and leaves the others alone. If an event sets a bit in the same cycle as a clear, the set wins.
- R7: `intrOut` is high exactly when some status bit and its interrupt enable are both 1. It stays high until that status bit is cleared or its enable is removed.
- R8: An enabled trigger event sampled at one edge makes `adcTrig` high for the following clock cycle only. Several enabled events in the same sample still give one single-cycle pulse.
- R9: When values coincide (load equals a compare value, or a compare value is zero), every matching event sets its status bit at the same edge.
- R10: Over one full up/down counter period, each of the six events is detected once. A trigger enabled only for compare-A-down fires exactly one pulse in that period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cntAdv | input | 1 | Counter advance strobe; events are sampled when it is high |
| cntVal | input | CNT_W | Current counter value |
| cntDown | input | 1 | 1 while the counter counts down |
| loadVal | input | CNT_W | Period (load) value |
| cmpA | input | CNT_W | Compare threshold A |
| cmpB | input | CNT_W | Compare threshold B |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 1 | 0 selects the enable register, 1 selects status clear |
| regWrData | input | REG_W | Write data |
| enRd | output | REG_W | Enable register readback |
| rawStat | output | 6 | Sticky raw event status |
| intrOut | output | 1 | Interrupt level |
| adcTrig | output | 1 | ADC trigger pulse |

## Verification
The assertions assume the counter inputs mean something only while `cntAdv` is high, and that register writes last one cycle. The stall property also relies on no status clear arriving while the counter is held. The bench drives every counter and register input on the falling edge and pulses `cntAdv` and `regWrEn` for exactly one cycle. The one deliberate overlap of a write with an advance is the set-versus-clear case. The full-period test steps a small triangle counter model through every value, so each event occurs in its natural order.

// File: rtl/pwm_evt_pkg.sv
package pwm_evt_pkg;
  localparam int EVT_N = 6;
  localparam int EV_ZERO  = 0;
  localparam int EV_LOAD  = 1;
  localparam int EV_AUP   = 2;
  localparam int EV_ADOWN = 3;
  localparam int EV_BUP   = 4;
  localparam int EV_BDOWN = 5;
  localparam int INT_LSB  = 0;
  localparam int TRG_LSB  = 8;

  typedef logic [EVT_N-1:0] evtVec_t;

  typedef struct packed {
    evtVec_t clrMask;
    evtVec_t intEn;
    evtVec_t trigEn;
  } ctrlStrb_t;
endpackage

// File: rtl/pwm_evt_ctrl.sv
module pwm_evt_ctrl
  import pwm_evt_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic             regSel,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] enRd,
  output ctrlStrb_t        strb
);
  evtVec_t intEnQ;
  evtVec_t trigEnQ;
  logic    enWr;
  logic    clrWr;

  assign enWr  = regWrEn && !regSel;
  assign clrWr = regWrEn && regSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intEnQ  <= '0;
      trigEnQ <= '0;
    end else if (enWr) begin
      intEnQ  <= regWrData[INT_LSB +: EVT_N];
      trigEnQ <= regWrData[TRG_LSB +: EVT_N];
    end
  end

  // readback: stored fields placed, everything else reads zero
  for (genvar b = 0; b < REG_W; b++) begin : g_rd
    if (b >= INT_LSB && b < INT_LSB + EVT_N) begin : g_int
      assign enRd[b] = intEnQ[b-INT_LSB];
    end else if (b >= TRG_LSB && b < TRG_LSB + EVT_N) begin : g_trg
      assign enRd[b] = trigEnQ[b-TRG_LSB];
    end else begin : g_rsv
      assign enRd[b] = 1'b0;
    end
  end

  always_comb begin
    strb.intEn   = intEnQ;
    strb.trigEn  = trigEnQ;
    strb.clrMask = clrWr ? regWrData[EVT_N-1:0] : '0;
  end
endmodule

// File: rtl/pwm_evt_detect.sv
module pwm_evt_detect
  import pwm_evt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             cntAdv,
  input  logic [CNT_W-1:0] cntVal,
  input  logic             cntDown,
  input  logic [CNT_W-1:0] loadVal,
  input  logic [CNT_W-1:0] cmpA,
  input  logic [CNT_W-1:0] cmpB,
  output evtVec_t          hit
);
  logic eqA;
  logic eqB;

  assign eqA = (cntVal == cmpA);
  assign eqB = (cntVal == cmpB);

  always_comb begin
    hit = '0;
    if (cntAdv) begin
      hit[EV_ZERO]  = (cntVal == '0);
      hit[EV_LOAD]  = (cntVal == loadVal);
      hit[EV_AUP]   = eqA && !cntDown;
      hit[EV_ADOWN] = eqA && cntDown;
      hit[EV_BUP]   = eqB && !cntDown;
      hit[EV_BDOWN] = eqB && cntDown;
    end
  end
endmodule

// File: rtl/pwm_evt_dp.sv
module pwm_evt_dp
  import pwm_evt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cntAdv,
  input  logic [CNT_W-1:0] cntVal,
  input  logic             cntDown,
  input  logic [CNT_W-1:0] loadVal,
  input  logic [CNT_W-1:0] cmpA,
  input  logic [CNT_W-1:0] cmpB,
  input  ctrlStrb_t        strb,
  output evtVec_t          rawStat,
  output logic             intrOut,
  output logic             adcTrig
);
  evtVec_t hit;
  evtVec_t statQ;
  logic    trigQ;

  pwm_evt_detect #(.CNT_W(CNT_W)) u_det (
    .cntAdv (cntAdv),
    .cntVal (cntVal),
    .cntDown(cntDown),
    .loadVal(loadVal),
    .cmpA   (cmpA),
    .cmpB   (cmpB),
    .hit    (hit)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statQ <= '0;
      trigQ <= 1'b0;
    end else begin
      // a new event outranks a clear in the same cycle
      statQ <= (statQ & ~strb.clrMask) | hit;
      trigQ <= |(hit & strb.trigEn);
    end
  end

  assign rawStat = statQ;
  assign intrOut = |(statQ & strb.intEn);
  assign adcTrig = trigQ;
endmodule

// File: rtl/pwm_event_gen.sv
module pwm_event_gen
  import pwm_evt_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cntAdv,
  input  logic [CNT_W-1:0] cntVal,
  input  logic             cntDown,
  input  logic [CNT_W-1:0] loadVal,
  input  logic [CNT_W-1:0] cmpA,
  input  logic [CNT_W-1:0] cmpB,
  input  logic             regWrEn,
  input  logic             regSel,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] enRd,
  output logic [5:0]       rawStat,
  output logic             intrOut,
  output logic             adcTrig
);
  ctrlStrb_t strb;

  pwm_evt_ctrl #(.REG_W(REG_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .regSel   (regSel),
    .regWrData(regWrData),
    .enRd     (enRd),
    .strb     (strb)
  );

  pwm_evt_dp #(.CNT_W(CNT_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .cntAdv (cntAdv),
    .cntVal (cntVal),
    .cntDown(cntDown),
    .loadVal(loadVal),
    .cmpA   (cmpA),
    .cmpB   (cmpB),
    .strb   (strb),
    .rawStat(rawStat),
    .intrOut(intrOut),
    .adcTrig(adcTrig)
  );
endmodule

// File: rtl/pwm_event_gen_chk.sv
module pwm_event_gen_chk #(
  parameter int REG_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             cntAdv,
  input logic             regWrEn,
  input logic             regSel,
  input logic [REG_W-1:0] regWrData,
  input logic [REG_W-1:0] enRd,
  input logic [5:0]       rawStat,
  input logic             intrOut,
  input logic             adcTrig
);
  // R2
  rsv_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enRd[REG_W-1:14] == '0) && (enRd[7:6] == 2'b00));

  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cntAdv && !regWrEn) |=> $stable(rawStat));

  // R5
  set_needs_adv_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((rawStat & ~$past(rawStat)) != 6'd0) |-> $past(cntAdv));

  // R6
  w1c_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regSel && !cntAdv) |=> ((rawStat & $past(regWrData[5:0])) == 6'd0));

  // R7
  intr_full_en_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((rawStat != 6'd0) && (enRd[5:0] == 6'h3F)) |-> intrOut);

  // R8
  trig_after_adv_chk: assert property (@(posedge clk) disable iff (!rstN)
    adcTrig |-> ($past(cntAdv) && ($past(enRd[13:8]) != 6'd0)));
endmodule

bind pwm_event_gen pwm_event_gen_chk #(.REG_W(REG_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cntAdv   (cntAdv),
  .regWrEn  (regWrEn),
  .regSel   (regSel),
  .regWrData(regWrData),
  .enRd     (enRd),
  .rawStat  (rawStat),
  .intrOut  (intrOut),
  .adcTrig  (adcTrig)
);

// File: tb/sim_pwm_event_gen.sv
`timescale 1ns/1ps
module sim_pwm_event_gen;
  localparam int CW = 16;
  localparam int RW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cntAdv = 1'b0;
  logic [CW-1:0] cntVal = '0;
  logic          cntDown = 1'b0;
  logic [CW-1:0] loadVal = 16'd100;
  logic [CW-1:0] cmpA = 16'd40;
  logic [CW-1:0] cmpB = 16'd60;
  logic          regWrEn = 1'b0;
  logic          regSel = 1'b0;
  logic [RW-1:0] regWrData = '0;
  logic [RW-1:0] enRd;
  logic [5:0]    rawStat;
  logic          intrOut;
  logic          adcTrig;

  int nChk = 0;
  int nFail = 0;

  always #5 clk = ~clk;

  pwm_event_gen #(.CNT_W(CW), .REG_W(RW)) u0 (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic sel, input logic [RW-1:0] d);
    regSel = sel; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic advance(input logic [CW-1:0] v, input logic dn);
    cntVal = v; cntDown = dn; cntAdv = 1'b1;
    @(negedge clk);
    cntAdv = 1'b0;
  endtask

  task automatic testReset();
    check("R1 enRd", enRd, 32'h0);
    check("R1 rawStat", {26'd0, rawStat}, 32'h0);
    check("R1 intrOut", {31'd0, intrOut}, 32'h0);
    check("R1 adcTrig", {31'd0, adcTrig}, 32'h0);
  endtask

  task automatic testEnableReg();
    regWrite(1'b0, 32'hFFFF_FFFF);
    check("R2 reserved masked", enRd, 32'h0000_3F3F);
    regWrite(1'b0, 32'h0000_0000);
    check("R2 cleared", enRd, 32'h0);
  endtask

  task automatic testEachEvent();
    logic [CW-1:0] vals [6];
    logic          dirs [6];
    vals = '{16'd0, 16'd100, 16'd40, 16'd40, 16'd60, 16'd60};
    dirs = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1};
    for (int i = 0; i < 6; i++) begin
      advance(vals[i], dirs[i]);
      check("R3 R5 single event bit", {26'd0, rawStat}, 32'(1 << i));
      check("R8 disabled no trigger", {31'd0, adcTrig}, 32'h0);
      regWrite(1'b1, 32'h3F);
      check("R6 cleared", {26'd0, rawStat}, 32'h0);
    end
  endtask

  task automatic testHold();
    cntVal = 16'd0; cntDown = 1'b0; regWrite(1'b0, 32'h0000_3F3F);
    repeat (3) @(negedge clk);
    check("R4 no set without advance", {26'd0, rawStat}, 32'h0);
    check("R4 no trigger without advance", {31'd0, adcTrig}, 32'h0);
    regWrite(1'b0, 32'h0);
  endtask

  task automatic testIntr();
    regWrite(1'b0, 32'h0000_0004);           // interrupt on A-up only
    advance(16'd40, 1'b1);
    check("R7 disabled bit no intr", {31'd0, intrOut}, 32'h0);
    check("R10 A-down bit", {26'd0, rawStat}, 32'h08);
    advance(16'd40, 1'b0);
    check("R7 intr raised", {31'd0, intrOut}, 32'h1);
    repeat (3) @(negedge clk);
    check("R7 intr held", {31'd0, intrOut}, 32'h1);
    regWrite(1'b1, 32'h08);
    check("R6 partial clear", {26'd0, rawStat}, 32'h04);
    check("R7 intr still held", {31'd0, intrOut}, 32'h1);
    regWrite(1'b1, 32'h04);
    check("R7 intr dropped", {31'd0, intrOut}, 32'h0);
    regWrite(1'b0, 32'h0);
  endtask

  task automatic testCoincide();
    cmpA = 16'd100;
    regWrite(1'b0, 32'h0000_0600);           // triggers on load and A-up
    advance(16'd100, 1'b0);
    check("R9 load and A-up together", {26'd0, rawStat}, 32'h06);
    check("R8 one pulse", {31'd0, adcTrig}, 32'h1);
    @(negedge clk);
    check("R8 pulse one cycle", {31'd0, adcTrig}, 32'h0);
    advance(16'd0, 1'b0);
    check("R8 unenabled event no pulse", {31'd0, adcTrig}, 32'h0);
    regWrite(1'b1, 32'h3F);
    cmpA = 16'd0;
    advance(16'd0, 1'b1);
    check("R9 zero and A-down together", {26'd0, rawStat}, 32'h09);
    regWrite(1'b1, 32'h3F);
    regWrite(1'b0, 32'h0);
    cmpA = 16'd40;
  endtask

  task automatic testSetWins();
    cntVal = 16'd60; cntDown = 1'b0; cntAdv = 1'b1;
    regSel = 1'b1; regWrData = 32'h10; regWrEn = 1'b1;
    @(negedge clk);
    cntAdv = 1'b0; regWrEn = 1'b0;
    check("R6 set beats clear", {26'd0, rawStat}, 32'h10);
    regWrite(1'b1, 32'h3F);
  endtask

  task automatic testPeriod();
    int pulses = 0;
    loadVal = 16'd10; cmpA = 16'd4; cmpB = 16'd7;
    regWrite(1'b0, 32'h0000_0800);           // trigger on A-down only
    for (int c = 0; c <= 10; c++) begin
      advance(CW'(c), 1'b0);
      if (adcTrig) pulses++;
    end
    for (int c = 9; c >= 1; c--) begin
      advance(CW'(c), 1'b1);
      if (adcTrig) pulses++;
    end
    check("R10 all six seen", {26'd0, rawStat}, 32'h3F);
    check("R10 single A-down pulse", 32'(pulses), 32'd1);
    regWrite(1'b1, 32'h3F);
    regWrite(1'b0, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testEnableReg();
    testEachEvent();
    testHold();
    testIntr();
    testCoincide();
    testSetWins();
    testPeriod();
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChk++;
    nFail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule